// File: doc/BRIEF.md
# Type-C Lane Mapping Controller

This block decides, for a four-pad USB/DisplayPort combo transmitter, which function each pad carries and which DisplayPort lane number lands on it. Pads 0 and 2 are bidirectional-capable, and pads 1 and 3 are transmit-only. The pad assignment comes from one of three sources, chosen at each load:

- A board-level static lane list, which wins whenever it is present.
- An orientation-driven default map, used when no list is present and the alternate DisplayPort function is requested.
- A plain USB-only configuration, used otherwise.

The block also produces the AUX channel polarity for both directions and a two-bit operating mode.

A static list holds up to four entries. Entry i names the pad that carries DisplayPort lane i. Only the first `list_count` entries are looked at. The list is checked for length, range and repeats. A bad list raises `cfg_err` and leaves the previous mapping in force, so downstream switching never sees a half-valid configuration. Every output is a register that changes only in the cycle after a `load` strobe.

Top module: `typec_lane_map`

## Requirements
- R1: After synchronous reset, all pads select USB (`pad_is_dp`=0), every pad lane index is 0, both AUX inversion outputs are 0, `mode` is USB-only (2'b01) and `cfg_err` is 0.
- R2: Outputs change only on the clock edge that samples `load`=1. They hold their values in every other cycle, whatever the other inputs do.
- R3: With no list, `alt_dp`=1 and `flip`=0, pads 2 and 3 carry DP (`pad_is_dp`=4'b1100). The per-pad lane indices for pads 0..3 are 3,2,0,1. AUX is not inverted, and `mode` is DP plus USB (2'b11).
- R4: With no list, `alt_dp`=1 and `flip`=1, pads 0 and 1 carry DP (`pad_is_dp`=4'b0011). The per-pad lane indices for pads 0..3 are 0,1,3,2. Both AUX inversion outputs are 1, and `mode` is 2'b11. The two AUX polarities are always equal.
- R5: With no list and `alt_dp`=0, `mode` is USB-only (2'b01), no pad carries DP, all lane indices are 0 and AUX is not inverted.
- R6: A present list whose `list_count` is neither 2 nor 4 sets `cfg_err`=1, and the mapping, lanes, AUX and mode outputs keep their previous values.
- R7: A present list with any counted entry greater than 3 sets `cfg_err`=1 and holds the previous mapping.
- R8: A present list in which two counted entries are equal sets `cfg_err`=1 and holds the previous mapping.
- R9: A valid 4-entry list gives `mode`=2'b10 (DP only) and makes every pad DP. Pad `entry[i]` gets lane index i, and AUX is not inverted.
- R10: A valid 2-entry list gives `mode`=2'b11. The two listed pads are DP with lane indices 0 and 1. The other pads are USB with lane index 0. Entries beyond the count are not checked. Entry i sits at `list_entries[3*i+2:3*i]`, and pad p's lane index at `pad_lane[2*p+1:2*p]`.
- R11: A valid load after an erroneous one clears `cfg_err` and applies the new mapping.
- R12: When a list is present, `flip` and `alt_dp` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe: evaluate the inputs and update the outputs |
| flip | input | 1 | Cable orientation, 1 = flipped |
| alt_dp | input | 1 | Request the orientation default map when no list is present |
| list_present | input | 1 | A static lane list is supplied |
| list_count | input | 3 | Number of list entries |
| list_entries | input | 12 | Four 3-bit entries; entry i names the pad for DP lane i |
| pad_is_dp | output | 4 | Per-pad select, 1 = DisplayPort, 0 = USB |
| pad_lane | output | 8 | Per-pad 2-bit DP lane index |
| aux_tx_inv | output | 1 | AUX output data inverted |
| aux_rx_inv | output | 1 | AUX input data inverted |
| mode | output | 2 | Bit 0 = USB active, bit 1 = DP active |
| cfg_err | output | 1 | Last load carried an invalid list |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check matters. They also assume that `load` is a level sampled on rising edges, with no requirement that it be a single-cycle pulse. The bench keeps within this by changing all inputs only on falling edges and raising `load` for exactly one cycle per configuration. It also changes the list, orientation and request inputs while `load` is low, so that the hold properties see real activity on the inputs. Error loads are always issued after a known valid mapping, so the hold behaviour compares against a known prior state.

// File: rtl/typec_map_pkg.sv
package typec_map_pkg;
  typedef enum logic [1:0] {
    MODE_USB  = 2'b01,
    MODE_DP   = 2'b10,
    MODE_BOTH = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/tcm_orient_map.sv
module tcm_orient_map #(
  parameter int NUM_PADS = 4,
  parameter int IDX_W    = $clog2(NUM_PADS)
) (
  input  logic                      flip,
  input  logic                      alt_dp,
  output logic [NUM_PADS-1:0]       dp_mask,
  output logic [NUM_PADS*IDX_W-1:0] lanes,
  output logic                      aux_inv,
  output logic [1:0]                mode
);
  import typec_map_pkg::*;
  localparam int HALF = NUM_PADS / 2;

  always_comb begin
    dp_mask = '0;
    lanes   = '0;
    aux_inv = 1'b0;
    mode    = MODE_USB;
    if (alt_dp) begin
      mode    = MODE_BOTH;
      aux_inv = flip;
      for (int p = 0; p < NUM_PADS; p++) begin
        if (!flip) begin
          dp_mask[p] = (p >= HALF);
          if (p < HALF) lanes[p*IDX_W +: IDX_W] = IDX_W'(NUM_PADS - 1 - p);
          else          lanes[p*IDX_W +: IDX_W] = IDX_W'(p - HALF);
        end else begin
          dp_mask[p] = (p < HALF);
          if (p < HALF) lanes[p*IDX_W +: IDX_W] = IDX_W'(p);
          else          lanes[p*IDX_W +: IDX_W] = IDX_W'(NUM_PADS - 1 - (p - HALF));
        end
      end
    end
  end
endmodule

// File: rtl/tcm_list_check.sv
module tcm_list_check #(
  parameter int NUM_PADS = 4,
  parameter int IDX_W    = $clog2(NUM_PADS),
  parameter int ENTRY_W  = IDX_W + 1,
  parameter int CNT_W    = $clog2(NUM_PADS + 1),
  parameter int PAIR_CNT = 2
) (
  input  logic [CNT_W-1:0]            count,
  input  logic [NUM_PADS*ENTRY_W-1:0] entries,
  output logic                        bad,
  output logic [NUM_PADS-1:0]         dp_mask,
  output logic [NUM_PADS*IDX_W-1:0]   lanes,
  output logic [1:0]                  mode
);
  import typec_map_pkg::*;

  logic [NUM_PADS-1:0] in_use;
  logic [NUM_PADS-1:0] out_of_range;
  logic [NUM_PADS-1:0] repeated;
  logic                count_ok;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PADS; gi++) begin : g_entry
      assign in_use[gi]       = (CNT_W'(gi) < count);
      assign out_of_range[gi] = in_use[gi] &&
        (entries[gi*ENTRY_W +: ENTRY_W] > ENTRY_W'(NUM_PADS - 1));
    end
  endgenerate

  always_comb begin
    repeated = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      for (int j = i + 1; j < NUM_PADS; j++) begin
        if (in_use[i] && in_use[j] &&
            entries[i*ENTRY_W +: ENTRY_W] == entries[j*ENTRY_W +: ENTRY_W])
          repeated[i] = 1'b1;
      end
    end
  end

  assign count_ok = (count == CNT_W'(PAIR_CNT)) || (count == CNT_W'(NUM_PADS));
  assign bad      = !count_ok || (|out_of_range) || (|repeated);
  assign mode     = (count == CNT_W'(NUM_PADS)) ? MODE_DP : MODE_BOTH;

  always_comb begin
    dp_mask = '0;
    lanes   = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      for (int i = 0; i < NUM_PADS; i++) begin
        if (in_use[i] && entries[i*ENTRY_W +: ENTRY_W] == ENTRY_W'(p)) begin
          dp_mask[p]              = 1'b1;
          lanes[p*IDX_W +: IDX_W] = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/typec_lane_map.sv
module typec_lane_map #(
  parameter int NUM_PADS = 4,
  parameter int IDX_W    = $clog2(NUM_PADS),
  parameter int ENTRY_W  = IDX_W + 1,
  parameter int CNT_W    = $clog2(NUM_PADS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        flip,
  input  logic                        alt_dp,
  input  logic                        list_present,
  input  logic [CNT_W-1:0]            list_count,
  input  logic [NUM_PADS*ENTRY_W-1:0] list_entries,
  output logic [NUM_PADS-1:0]         pad_is_dp,
  output logic [NUM_PADS*IDX_W-1:0]   pad_lane,
  output logic                        aux_tx_inv,
  output logic                        aux_rx_inv,
  output logic [1:0]                  mode,
  output logic                        cfg_err
);
  import typec_map_pkg::*;

  logic [NUM_PADS-1:0]       def_mask, lst_mask, nxt_mask;
  logic [NUM_PADS*IDX_W-1:0] def_lanes, lst_lanes, nxt_lanes;
  logic [1:0]                def_mode, lst_mode, nxt_mode;
  logic                      def_aux, nxt_aux, lst_bad;

  tcm_orient_map #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W)) u_orient (
    .flip    (flip),
    .alt_dp  (alt_dp),
    .dp_mask (def_mask),
    .lanes   (def_lanes),
    .aux_inv (def_aux),
    .mode    (def_mode)
  );

  tcm_list_check #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W),
                   .CNT_W(CNT_W)) u_list (
    .count   (list_count),
    .entries (list_entries),
    .bad     (lst_bad),
    .dp_mask (lst_mask),
    .lanes   (lst_lanes),
    .mode    (lst_mode)
  );

  // The static list overrides the orientation path entirely.
  always_comb begin
    if (list_present) begin
      nxt_mask  = lst_mask;
      nxt_lanes = lst_lanes;
      nxt_mode  = lst_mode;
      nxt_aux   = 1'b0;
    end else begin
      nxt_mask  = def_mask;
      nxt_lanes = def_lanes;
      nxt_mode  = def_mode;
      nxt_aux   = def_aux;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_is_dp  <= '0;
      pad_lane   <= '0;
      aux_tx_inv <= 1'b0;
      aux_rx_inv <= 1'b0;
      mode       <= MODE_USB;
      cfg_err    <= 1'b0;
    end else if (load) begin
      cfg_err <= list_present && lst_bad;
      if (!(list_present && lst_bad)) begin
        pad_is_dp  <= nxt_mask;
        pad_lane   <= nxt_lanes;
        aux_tx_inv <= nxt_aux;
        aux_rx_inv <= nxt_aux;
        mode       <= nxt_mode;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(rst)) |-> ($stable(pad_is_dp) && $stable(pad_lane)
      && $stable(mode) && $stable(aux_tx_inv) && $stable(cfg_err)));

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !$past(rst)) |-> ($stable(pad_is_dp) && $stable(pad_lane)
      && $stable(mode) && $stable(aux_rx_inv)));

  p_aux_pair_r4: assert property (@(posedge clk) disable iff (rst)
    aux_tx_inv == aux_rx_inv);

  p_aux_flip_r4: assert property (@(posedge clk) disable iff (rst)
    aux_tx_inv |-> (mode == MODE_BOTH && pad_is_dp != '0));

  p_usb_only_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_USB) |-> (pad_is_dp == '0));

  p_dp_only_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DP) |-> (&pad_is_dp));

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b00);
endmodule

// File: tb/typec_lane_map_test.sv
module typec_lane_map_test;
  logic        clk = 1'b0;
  logic        rst, load, flip, alt_dp, list_present;
  logic [2:0]  list_count;
  logic [11:0] list_entries;
  logic [3:0]  pad_is_dp;
  logic [7:0]  pad_lane;
  logic        aux_tx_inv, aux_rx_inv, cfg_err;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  typec_lane_map uut (
    .clk(clk), .rst(rst), .load(load), .flip(flip), .alt_dp(alt_dp),
    .list_present(list_present), .list_count(list_count),
    .list_entries(list_entries), .pad_is_dp(pad_is_dp), .pad_lane(pad_lane),
    .aux_tx_inv(aux_tx_inv), .aux_rx_inv(aux_rx_inv), .mode(mode),
    .cfg_err(cfg_err)
  );

  // [34]=flip [33]=alt [32]=present [31:29]=count [28:17]=entries
  // [16]=err [15:12]=dp [11:4]=lanes [3]=txinv [2]=rxinv [1:0]=mode
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,3'd0,12'h000, 1'b0,4'b1100,8'h4B,1'b0,1'b0,2'b11},
    {1'b1,1'b1,1'b0,3'd0,12'h000, 1'b0,4'b0011,8'hB4,1'b1,1'b1,2'b11},
    {1'b1,1'b0,1'b0,3'd0,12'h000, 1'b0,4'b0000,8'h00,1'b0,1'b0,2'b01},
    {1'b0,1'b0,1'b1,3'd4,{3'd3,3'd2,3'd1,3'd0}, 1'b0,4'b1111,8'hE4,1'b0,1'b0,2'b10},
    {1'b1,1'b1,1'b1,3'd4,{3'd1,3'd0,3'd3,3'd2}, 1'b0,4'b1111,8'h4E,1'b0,1'b0,2'b10},
    {1'b1,1'b1,1'b1,3'd2,{3'd0,3'd0,3'd1,3'd0}, 1'b0,4'b0011,8'h04,1'b0,1'b0,2'b11},
    {1'b0,1'b0,1'b1,3'd2,{3'd0,3'd0,3'd3,3'd2}, 1'b0,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b0,1'b1,1'b1,3'd3,{3'd0,3'd2,3'd1,3'd0}, 1'b1,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b0,1'b0,1'b1,3'd2,{3'd0,3'd0,3'd1,3'd4}, 1'b1,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b0,1'b0,1'b1,3'd4,{3'd3,3'd2,3'd1,3'd1}, 1'b1,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b1,1'b1,1'b1,3'd2,{3'd0,3'd0,3'd3,3'd3}, 1'b1,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b0,1'b0,1'b1,3'd0,12'h000,               1'b1,4'b1100,8'h40,1'b0,1'b0,2'b11},
    {1'b0,1'b0,1'b1,3'd2,{3'd1,3'd7,3'd0,3'd1}, 1'b0,4'b0011,8'h01,1'b0,1'b0,2'b11}
  };

  function automatic string tag_of(int k);
    case (k)
      0: return "R3 default unflipped";
      1: return "R4 default flipped";
      2: return "R5 usb only";
      3: return "R9 four-entry identity";
      4: return "R9 R12 four-entry permuted";
      5: return "R10 R12 two-entry low pads";
      6: return "R10 two-entry high pads";
      7: return "R6 bad count 3";
      8: return "R7 entry out of range";
      9: return "R8 repeat in four";
      10: return "R8 R12 repeat in two";
      11: return "R6 bad count 0";
      default: return "R11 R10 recover, tail ignored";
    endcase
  endfunction

  function automatic logic [16:0] observed();
    return {cfg_err, pad_is_dp, pad_lane, aux_tx_inv, aux_rx_inv, mode};
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [34:0] v);
    @(negedge clk);
    {flip, alt_dp, list_present, list_count, list_entries} = v[34:17];
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; flip = 1'b0; alt_dp = 1'b0;
    list_present = 1'b0; list_count = '0; list_entries = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", observed(), {1'b0,4'b0000,8'h00,1'b0,1'b0,2'b01});

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check(tag_of(k), observed(), VEC[k][16:0]);
    end

    // R2: inputs move with load low, outputs hold
    @(negedge clk);
    flip = 1'b1; alt_dp = 1'b1; list_present = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 no load no change", observed(), {1'b0,4'b0011,8'h01,1'b0,1'b0,2'b11});
    list_present = 1'b1; list_count = 3'd4; list_entries = {3'd0,3'd1,3'd2,3'd3};
    @(negedge clk);
    check("R2 list change ignored", observed(), {1'b0,4'b0011,8'h01,1'b0,1'b0,2'b11});

    // R2: update lands exactly one edge after the strobe
    load = 1'b1;
    @(posedge clk);
    #1;
    load = 1'b0;
    check("R2 one cycle update", observed(), {1'b0,4'b1111,8'h1B,1'b0,1'b0,2'b10});

    // R11: error then valid default
    apply({1'b0,1'b0,1'b1,3'd1,12'h000, 17'h0});
    check("R6 count 1 held", observed(), {1'b1,4'b1111,8'h1B,1'b0,1'b0,2'b10});
    apply({1'b1,1'b1,1'b0,3'd0,12'h000, 17'h0});
    check("R11 R4 clear to flipped", observed(), {1'b0,4'b0011,8'hB4,1'b1,1'b1,2'b11});

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset after use", observed(), {1'b0,4'b0000,8'h00,1'b0,1'b0,2'b01});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule